// File: doc/BRIEF.md
# Row Writeback Sweep Sequencer

A write back of one dirty block from the last-level cache starts this sequencer. Its job is to gather the other dirty blocks that live in the same DRAM row, so that they reach memory in one burst and hit the open row. The sequencer does not probe the tag store once for every block position in the row. It makes one query to a row-organised dirty index and gets back a single bit vector for the whole row. It then works through that vector and issues a cache lookup and write back request only where a bit is set. Each request clears its bit in the index.

A row holds 128 blocks of 64 bytes (about 8 KB), so the vector is 128 bits wide. Bit i of the vector stands for block i of the row. The triggering block is excluded from the sweep because it is already on its way out. Set bits are served in ascending block order, at most one request per cycle, under a valid/ready handshake. The sequencer handles one row at a time. A second trigger waits on the ready signal until the current row is finished. The sequencer marks the end of each row with a one-cycle done pulse.

Top module: `row_sweep_seq`

## Requirements
- R1: After reset, trig_ready is 1 and wb_valid, idx_rd_en, idx_clr_en and sweep_done are 0.
- R2: A trigger is accepted in a cycle where trig_valid and trig_ready are both 1. In the next cycle, idx_rd_en is 1 for exactly one cycle and idx_rd_row equals the accepted row.
- R3: The index presents the row vector on idx_rd_vec in the cycle after idx_rd_en. A write back request (wb_valid=1) is raised only for block positions i whose bit i is set in that vector. Every request carries the accepted row on wb_row.
- R4: Requests come out in strictly ascending block order, and each one is accepted on wb_valid and wb_ready together. While wb_ready is 0, wb_row and wb_blk hold steady. The first request can appear in the cycle after the vector is presented.
- R5: The bit at the triggering block's own position is never requested and never cleared.
- R6: In the cycle a request is accepted, idx_clr_en is 1 and idx_clr_row/idx_clr_blk equal wb_row/wb_blk. idx_clr_en is 0 in every other cycle. After a sweep, every bit of the row except the trigger's own bit is clear in the index.
- R7: trig_ready is 0 from the cycle after acceptance until the sweep ends. A trigger held valid during that time is not taken.
- R8: sweep_done is a one-cycle pulse in the first cycle after the vector is loaded in which no requested bits remain, with wb_valid at 0. An empty vector, or one holding only the trigger's own bit, gives the pulse in the cycle after the vector is presented. trig_ready returns to 1 in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| trig_valid | input | 1 | A dirty block write back has started |
| trig_ready | output | 1 | Sequencer idle and able to take a trigger |
| trig_row | input | ROW_W | DRAM row of the triggering block |
| trig_blk | input | BLK_W | Block position of the trigger within its row |
| idx_rd_en | output | 1 | Dirty index row query |
| idx_rd_row | output | ROW_W | Row being queried |
| idx_rd_vec | input | BLKS | Row dirty vector, valid the cycle after the query |
| idx_clr_en | output | 1 | Clear one dirty bit in the index |
| idx_clr_row | output | ROW_W | Row of the bit to clear |
| idx_clr_blk | output | BLK_W | Position of the bit to clear |
| wb_valid | output | 1 | Write back request pending |
| wb_ready | input | 1 | Request taken by the cache side |
| wb_row | output | ROW_W | Row of the requested block |
| wb_blk | output | BLK_W | Block position of the request |
| sweep_done | output | 1 | One-cycle pulse at the end of a row |

## Verification
The assertions assume that the index answers a query with a vector in the cycle after idx_rd_en, and that the cache side never withdraws a request it has been offered. The assertions also rely on idx_rd_vec having no meaning outside that one cycle. The bench keeps within these limits by serving the index from a behavioural row table with exactly one cycle of read latency. Only the bench drives wb_ready, either held high, alternating or random. It never drives any output the design owns. Back-to-back triggers are sent with the second trigger held valid while the first row is still being swept. Each sweep therefore ends before any other row is queried.

// File: rtl/rws_pkg.sv
// Package: shared types for the row writeback sweep sequencer.
// Assumes: nothing beyond being compiled before the modules that use it.
package rws_pkg;

    // Control phases of one row sweep.
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,
        PH_QUERY = 2'd1,
        PH_LOAD  = 2'd2,
        PH_SWEEP = 2'd3
    } sweep_phase_e;

endpackage

// File: rtl/rws_lowest_set.sv
// Module: finds the lowest set bit of a vector and reports whether any bit is set.
// Assumes: N >= 1 and W wide enough to hold N-1. Purely combinational.
module rws_lowest_set #(
    parameter int N = 128,
    parameter int W = $clog2(N)
) (
    input  logic [N-1:0] vec,
    output logic [W-1:0] idx,
    output logic         any
);

    logic [N:0]   seen;
    logic [N-1:0] first;

    assign seen[0] = 1'b0;

    // Prefix chain: each position learns whether a lower bit is already set.
    for (genvar b = 0; b < N; b++) begin : g_chain
        assign seen[b+1] = seen[b] | vec[b];
        assign first[b]  = vec[b] & ~seen[b];
    end

    assign any = seen[N];

    // Encode the one-hot lowest bit into a position number.
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) begin
                idx = idx | W'(i);
            end
        end
    end

endmodule

// File: rtl/rws_pending.sv
// Module: local copy of the row dirty vector still to be served.
// Assumes: load and clr are never asserted together; on load, the trigger's
// own position is masked out so it never reaches the request output.
module rws_pending #(
    parameter int N = 128,
    parameter int W = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load,
    input  logic [N-1:0] load_vec,
    input  logic [W-1:0] skip_idx,
    input  logic         clr,
    input  logic [W-1:0] clr_idx,
    output logic [N-1:0] pend
);

    for (genvar b = 0; b < N; b++) begin : g_bit
        logic q;

        // Per-position flag: set from the fetched vector, dropped when served.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                q <= 1'b0;
            end else if (load) begin
                q <= load_vec[b] & (skip_idx != W'(b));
            end else if (clr && (clr_idx == W'(b))) begin
                q <= 1'b0;
            end
        end

        assign pend[b] = q;
    end

endmodule

// File: rtl/rws_ctrl.sv
// Module: phase control for one row sweep: accept, query, load, serve, finish.
// Assumes: the index answers a query in the next cycle; pend_any reflects the
// pending copy held by rws_pending.
module rws_ctrl
    import rws_pkg::*;
#(
    parameter int ROW_W = 16,
    parameter int W     = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_valid,
    input  logic [ROW_W-1:0] trig_row,
    input  logic [W-1:0]     trig_blk,
    input  logic             pend_any,
    input  logic             wb_ready,
    output logic             trig_ready,
    output logic             query,
    output logic             load,
    output logic             req_valid,
    output logic             fire,
    output logic             done,
    output logic [ROW_W-1:0] row_q,
    output logic [W-1:0]     blk_q
);

    sweep_phase_e phase, phase_nx;
    logic         accept;

    assign accept     = trig_valid && (phase == PH_IDLE);
    assign trig_ready = (phase == PH_IDLE);
    assign query      = (phase == PH_QUERY);
    assign load       = (phase == PH_LOAD);
    assign req_valid  = (phase == PH_SWEEP) && pend_any;
    assign fire       = req_valid && wb_ready;
    assign done       = (phase == PH_SWEEP) && !pend_any;

    // Next-phase selection.
    always_comb begin
        phase_nx = phase;
        unique case (phase)
            PH_IDLE:  if (accept) phase_nx = PH_QUERY;
            PH_QUERY: phase_nx = PH_LOAD;
            PH_LOAD:  phase_nx = PH_SWEEP;
            PH_SWEEP: if (!pend_any) phase_nx = PH_IDLE;
            default:  phase_nx = PH_IDLE;
        endcase
    end

    // Phase register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
        end else begin
            phase <= phase_nx;
        end
    end

    // Capture the trigger's row and block when it is taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_q <= '0;
            blk_q <= '0;
        end else if (accept) begin
            row_q <= trig_row;
            blk_q <= trig_blk;
        end
    end

endmodule

// File: rtl/row_sweep_seq.sv
// Module: top of the row writeback sweep sequencer. On a trigger, it reads
// the row's dirty vector once, then issues ascending write back requests for
// every set bit except the trigger's own, clearing each bit in the index as
// its request is taken.
// Assumes: index read latency of one cycle; BLKS is a power of two.
module row_sweep_seq #(
    parameter int ROW_W = 16,
    parameter int BLKS  = 128,
    parameter int BLK_W = $clog2(BLKS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             trig_valid,
    output logic             trig_ready,
    input  logic [ROW_W-1:0] trig_row,
    input  logic [BLK_W-1:0] trig_blk,
    output logic             idx_rd_en,
    output logic [ROW_W-1:0] idx_rd_row,
    input  logic [BLKS-1:0]  idx_rd_vec,
    output logic             idx_clr_en,
    output logic [ROW_W-1:0] idx_clr_row,
    output logic [BLK_W-1:0] idx_clr_blk,
    output logic             wb_valid,
    input  logic             wb_ready,
    output logic [ROW_W-1:0] wb_row,
    output logic [BLK_W-1:0] wb_blk,
    output logic             sweep_done
);

    logic [BLKS-1:0]  pend;
    logic             pend_any;
    logic [BLK_W-1:0] next_blk;
    logic             load;
    logic             fire;
    logic [ROW_W-1:0] row_q;
    logic [BLK_W-1:0] blk_q;

    rws_ctrl #(
        .ROW_W (ROW_W),
        .W     (BLK_W)
    ) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .trig_valid (trig_valid),
        .trig_row   (trig_row),
        .trig_blk   (trig_blk),
        .pend_any   (pend_any),
        .wb_ready   (wb_ready),
        .trig_ready (trig_ready),
        .query      (idx_rd_en),
        .load       (load),
        .req_valid  (wb_valid),
        .fire       (fire),
        .done       (sweep_done),
        .row_q      (row_q),
        .blk_q      (blk_q)
    );

    rws_pending #(
        .N (BLKS),
        .W (BLK_W)
    ) u_pend (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_vec (idx_rd_vec),
        .skip_idx (blk_q),
        .clr      (fire),
        .clr_idx  (next_blk),
        .pend     (pend)
    );

    rws_lowest_set #(
        .N (BLKS),
        .W (BLK_W)
    ) u_find (
        .vec (pend),
        .idx (next_blk),
        .any (pend_any)
    );

    assign idx_rd_row  = row_q;
    assign wb_row      = row_q;
    assign wb_blk      = next_blk;
    assign idx_clr_en  = fire;
    assign idx_clr_row = row_q;
    assign idx_clr_blk = next_blk;

endmodule

// File: rtl/rws_checker.sv
// Module: protocol and ordering checks for row_sweep_seq, attached by bind.
// Assumes: index answers one cycle after a query; cache side never withdraws.
module rws_checker #(
    parameter int ROW_W = 16,
    parameter int BLK_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             trig_valid,
    input logic             trig_ready,
    input logic [ROW_W-1:0] trig_row,
    input logic [BLK_W-1:0] trig_blk,
    input logic             idx_rd_en,
    input logic [ROW_W-1:0] idx_rd_row,
    input logic             idx_clr_en,
    input logic [ROW_W-1:0] idx_clr_row,
    input logic [BLK_W-1:0] idx_clr_blk,
    input logic             wb_valid,
    input logic             wb_ready,
    input logic [ROW_W-1:0] wb_row,
    input logic [BLK_W-1:0] wb_blk,
    input logic             sweep_done
);

    logic [BLK_W-1:0] own_blk;

    // Remember the accepted trigger's block position.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            own_blk <= '0;
        end else if (trig_valid && trig_ready) begin
            own_blk <= trig_blk;
        end
    end

    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (trig_ready && !wb_valid && !idx_rd_en && !idx_clr_en && !sweep_done));

    a_r2_query_follows_accept: assert property (@(posedge clk) disable iff (!rst_n)
        (trig_valid && trig_ready) |=> (idx_rd_en && idx_rd_row == $past(trig_row)));

    a_r2_single_query: assert property (@(posedge clk) disable iff (!rst_n)
        idx_rd_en |=> !idx_rd_en);

    a_r4_hold_when_stalled: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_blk) && $stable(wb_row)));

    a_r4_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready) |=> (!wb_valid || wb_blk > $past(wb_blk)));

    a_r5_own_bit_skipped: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid |-> (wb_blk != own_blk));

    a_r6_clear_matches_request: assert property (@(posedge clk) disable iff (!rst_n)
        idx_clr_en |-> (wb_valid && wb_ready && idx_clr_blk == wb_blk && idx_clr_row == wb_row));

    a_r6_clear_on_handshake: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && wb_ready) |-> idx_clr_en);

    a_r7_busy_blocks_trigger: assert property (@(posedge clk) disable iff (!rst_n)
        (idx_rd_en || wb_valid) |-> !trig_ready);

    a_r8_done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |=> (!sweep_done && trig_ready));

    a_r8_done_without_request: assert property (@(posedge clk) disable iff (!rst_n)
        sweep_done |-> !wb_valid);

endmodule

bind row_sweep_seq rws_checker #(
    .ROW_W (ROW_W),
    .BLK_W (BLK_W)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .trig_valid  (trig_valid),
    .trig_ready  (trig_ready),
    .trig_row    (trig_row),
    .trig_blk    (trig_blk),
    .idx_rd_en   (idx_rd_en),
    .idx_rd_row  (idx_rd_row),
    .idx_clr_en  (idx_clr_en),
    .idx_clr_row (idx_clr_row),
    .idx_clr_blk (idx_clr_blk),
    .wb_valid    (wb_valid),
    .wb_ready    (wb_ready),
    .wb_row      (wb_row),
    .wb_blk      (wb_blk),
    .sweep_done  (sweep_done)
);

// File: tb/sim_row_sweep_seq.sv
// Bench: behavioural dirty index, behavioural sweep model compared every cycle.
module sim_row_sweep_seq;

    localparam int ROW_W = 16;
    localparam int BLKS  = 128;
    localparam int BLK_W = 7;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             trig_valid = 1'b0;
    logic             trig_ready;
    logic [ROW_W-1:0] trig_row = '0;
    logic [BLK_W-1:0] trig_blk = '0;
    logic             idx_rd_en;
    logic [ROW_W-1:0] idx_rd_row;
    logic [BLKS-1:0]  idx_rd_vec = '0;
    logic             idx_clr_en;
    logic [ROW_W-1:0] idx_clr_row;
    logic [BLK_W-1:0] idx_clr_blk;
    logic             wb_valid;
    logic             wb_ready = 1'b1;
    logic [ROW_W-1:0] wb_row;
    logic [BLK_W-1:0] wb_blk;
    logic             sweep_done;

    int tests = 0;
    int fails = 0;
    int rmode = 0;
    bit finished = 0;

    logic [BLKS-1:0] mem [logic [ROW_W-1:0]];

    always #5 clk = ~clk;

    row_sweep_seq #(.ROW_W(ROW_W), .BLKS(BLKS)) u0 (
        .clk(clk), .rst_n(rst_n),
        .trig_valid(trig_valid), .trig_ready(trig_ready),
        .trig_row(trig_row), .trig_blk(trig_blk),
        .idx_rd_en(idx_rd_en), .idx_rd_row(idx_rd_row), .idx_rd_vec(idx_rd_vec),
        .idx_clr_en(idx_clr_en), .idx_clr_row(idx_clr_row), .idx_clr_blk(idx_clr_blk),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_row(wb_row), .wb_blk(wb_blk),
        .sweep_done(sweep_done)
    );

    task automatic chk(input string req, input string what, input longint act, input longint exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chkv(input string req, input string what, input logic [BLKS-1:0] act,
                        input logic [BLKS-1:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Dirty index model: one-cycle read, clear on request.
    always @(posedge clk) begin
        if (idx_rd_en) idx_rd_vec <= mem.exists(idx_rd_row) ? mem[idx_rd_row] : '0;
        if (rst_n && idx_clr_en && mem.exists(idx_clr_row))
            mem[idx_clr_row] = mem[idx_clr_row] & ~(128'b1 << idx_clr_blk);
    end

    // Cache-side acceptance pattern.
    initial begin
        forever begin
            @(posedge clk);
            #1;
            case (rmode)
                0: wb_ready = 1'b1;
                1: wb_ready = 1'($urandom % 2);
                default: wb_ready = ~wb_ready;
            endcase
        end
    end

    // Reference model, checked and advanced away from the active edge.
    int               ph = 0;
    logic [ROW_W-1:0] m_row;
    int               m_blk;
    int               q[$];

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            case (ph)
                0: begin
                    chk("R7", "trig_ready idle", trig_ready, 1);
                    chk("R2", "idx_rd_en idle", idx_rd_en, 0);
                    chk("R3", "wb_valid idle", wb_valid, 0);
                    chk("R8", "sweep_done idle", sweep_done, 0);
                    chk("R6", "idx_clr_en idle", idx_clr_en, 0);
                    if (trig_valid) begin
                        m_row = trig_row;
                        m_blk = int'(trig_blk);
                        ph = 1;
                    end
                end
                1: begin
                    chk("R7", "trig_ready query", trig_ready, 0);
                    chk("R2", "idx_rd_en query", idx_rd_en, 1);
                    chk("R2", "idx_rd_row", idx_rd_row, m_row);
                    chk("R3", "wb_valid query", wb_valid, 0);
                    ph = 2;
                end
                2: begin
                    chk("R7", "trig_ready load", trig_ready, 0);
                    chk("R2", "idx_rd_en load", idx_rd_en, 0);
                    chk("R3", "wb_valid load", wb_valid, 0);
                    chk("R8", "sweep_done load", sweep_done, 0);
                    q.delete();
                    for (int i = 0; i < BLKS; i++)
                        if (idx_rd_vec[i] && i != m_blk) q.push_back(i);
                    ph = 3;
                end
                default: begin
                    chk("R7", "trig_ready sweep", trig_ready, 0);
                    chk("R2", "idx_rd_en sweep", idx_rd_en, 0);
                    if (q.size() == 0) begin
                        chk("R8", "sweep_done at end", sweep_done, 1);
                        chk("R3", "wb_valid at end", wb_valid, 0);
                        chk("R6", "idx_clr_en at end", idx_clr_en, 0);
                        ph = 0;
                    end else begin
                        chk("R8", "sweep_done early", sweep_done, 0);
                        chk("R3", "wb_valid pending", wb_valid, 1);
                        chk("R3", "wb_row", wb_row, m_row);
                        chk("R4", "wb_blk order", wb_blk, q[0]);
                        chk("R6", "idx_clr_en", idx_clr_en, wb_ready);
                        if (wb_ready) begin
                            chk("R6", "idx_clr_blk", idx_clr_blk, q[0]);
                            chk("R6", "idx_clr_row", idx_clr_row, m_row);
                            void'(q.pop_front());
                        end
                    end
                end
            endcase
        end
    end

    task automatic issue(input logic [ROW_W-1:0] row, input int blk);
        trig_valid = 1'b1;
        trig_row   = row;
        trig_blk   = BLK_W'(blk);
        @(negedge clk);
        while (!trig_ready) @(negedge clk);
        @(posedge clk);
        #1;
        trig_valid = 1'b0;
    endtask

    task automatic wait_done();
        @(negedge clk);
        while (!sweep_done) @(negedge clk);
        @(posedge clk);
        #1;
    endtask

    task automatic post_check(input logic [ROW_W-1:0] row, input int blk, input logic [BLKS-1:0] vec);
        logic [BLKS-1:0] own;
        own = 128'b1 << blk;
        chkv("R6", "row cleared after sweep", mem[row] & ~own, '0);
        chkv("R5", "own bit untouched", mem[row] & own, vec & own);
    endtask

    task automatic sweep(input logic [ROW_W-1:0] row, input int blk, input logic [BLKS-1:0] vec, input int mode);
        rmode = mode;
        mem[row] = vec;
        issue(row, blk);
        wait_done();
        post_check(row, blk, vec);
    endtask

    initial begin
        logic [BLKS-1:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "trig_ready after reset", trig_ready, 1);
        chk("R1", "wb_valid after reset", wb_valid, 0);
        chk("R1", "idx_rd_en after reset", idx_rd_en, 0);
        chk("R1", "sweep_done after reset", sweep_done, 0);
        @(posedge clk);
        #1;

        // R3 R4: several set bits, cache always ready.
        v = '0; v[1] = 1; v[5] = 1; v[9] = 1; v[40] = 1; v[127] = 1;
        sweep(16'h0012, 5, v, 0);
        // R4: random stalls, trigger at position 0.
        v = '0; v[0] = 1; v[3] = 1; v[64] = 1; v[100] = 1;
        sweep(16'h1234, 0, v, 1);
        // R8: empty vector.
        sweep(16'h0007, 10, '0, 0);
        // R5 R8: only the trigger's own bit.
        v = '0; v[127] = 1;
        sweep(16'h0008, 127, v, 0);
        // R3 R4: end positions with alternating ready.
        v = '0; v[0] = 1; v[60] = 1; v[127] = 1;
        sweep(16'h0009, 60, v, 2);
        // R4 R6: full row under random stalls.
        sweep(16'hFFFF, 64, '1, 1);
        // R8: row never entered in the index.
        rmode = 0;
        issue(16'h0abc, 3);
        wait_done();

        // R7: second trigger held while the first row is being swept.
        rmode = 1;
        v = '0; v[2] = 1; v[3] = 1; v[4] = 1;
        mem[16'h0020] = v;
        mem[16'h0021] = (128'b1 << 1) | (128'b1 << 126);
        issue(16'h0020, 2);
        issue(16'h0021, 0);
        wait_done();
        post_check(16'h0020, 2, v);
        post_check(16'h0021, 0, (128'b1 << 1) | (128'b1 << 126));

        repeat (4) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    // Watchdog.
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1;
            tests++;
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule